// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides a fast input clock by a programmable ratio of eight times a main count plus a swallow count. A two-modulus prescaler divides by nine while swallow cycles remain in the current output period and by eight for the rest of the period. A period counter counts prescaler cycles up to the main count. The swallow count fixes how many of those cycles take the longer modulus. At the start of each output period the block emits a pulse that lasts exactly eight input cycles, which is one base prescaler cycle.

An active-high hold input stops the block. While hold is high, all counters stay cleared, the output stays low, and the main and swallow inputs are loaded continuously. When hold is released the block starts counting. After that, new input values are picked up only at period boundaries. The block clamps inconsistent settings and reports them on a status output.

Top module: `psd_top`

## Requirements
- R1: With 2 ≤ main ≤ 255 and swallow ≤ main, consecutive rising edges of `div_out` are exactly 8·main + swallow input clock cycles apart.
- R2: Every `div_out` pulse that no hold cuts short stays high for exactly 8 input clock cycles.
- R3: A swallow value of 0 gives a pure divide-by-8 prescaler, so the ratio is 8·main.
- R4: While `hold` is high, `div_out` is low from the clock edge after hold is sampled high. On the first clock edge that samples `hold` low, `div_out` goes high and a new period begins.
- R5: Changes to `swallow_in` and `main_in` while running do not alter the period in progress. They take effect from the next period.
- R6: When swallow > main, swallow is clamped to main, so the ratio is 9·main, and `cfg_bad` is 1.
- R7: A main value of 0 is treated as 1, with swallow clamped to 1, and `cfg_bad` is 1. For example, main 0 with swallow 5 gives a ratio of 9.
- R8: `cfg_bad` describes the setting in effect. It changes only on a clock edge where `hold` is high or where a new period starts.
- R9: When swallow equals main, every prescaler cycle divides by 9, so the ratio is 9·main, and the pulse width is still 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| hold | input | 1 | Active-high synchronous hold; clears counters and loads settings |
| swallow_in | input | A_W (6) | Swallow count: number of divide-by-9 prescaler cycles per period |
| main_in | input | M_W (8) | Main count: number of prescaler cycles per period |
| div_out | output | 1 | Divider output pulse, 8 input cycles wide |
| cfg_bad | output | 1 | Set when the loaded setting was clamped |

## Verification
There is one register stage between an edge that samples `hold` low and the rise of `div_out`. The bench therefore releases hold at a falling edge and checks for a high output at the next falling edge. Pulse width and period are counted in falling-edge samples from one rise of `div_out` to the next. This is exact because every output transition is registered on a rising edge. `cfg_bad` is due one edge after a loading edge, so the bench reads it at the falling edge after hold has covered two rising edges. In the boundary test the first period is measured with the old setting and the second with the new one.

// File: rtl/psd_pkg.sv
package psd_pkg;

    // Base modulus of the two-modulus prescaler
    localparam int PRE_BASE = 8;
    localparam int PRE_W    = $clog2(PRE_BASE + 1);

    typedef enum logic {
        MOD_BASE = 1'b0,   // divide by PRE_BASE
        MOD_EXT  = 1'b1    // divide by PRE_BASE + 1
    } modsel_e;

    // Last prescaler count value for the selected modulus
    function automatic logic [PRE_W-1:0] pre_last(input modsel_e sel);
        if (sel == MOD_EXT) pre_last = PRE_W'(PRE_BASE);
        else                pre_last = PRE_W'(PRE_BASE - 1);
    endfunction

endpackage

// File: rtl/psd_cfg_clamp.sv
module psd_cfg_clamp #(
    parameter int A_W = 6,
    parameter int M_W = 8
) (
    input  logic [A_W-1:0] a_in,
    input  logic [M_W-1:0] m_in,
    output logic [M_W-1:0] a_eff,
    output logic [M_W-1:0] m_eff,
    output logic           bad
);
    localparam int CMP_W = (A_W > M_W) ? A_W : M_W;

    logic [CMP_W-1:0] a_x, m_x, m_fix, a_sel;

    always_comb begin
        a_x   = CMP_W'(a_in);
        m_x   = CMP_W'(m_in);
        m_fix = (m_in == '0) ? CMP_W'(1) : m_x;
        a_sel = (a_x > m_fix) ? m_fix : a_x;
        a_eff = a_sel[M_W-1:0];
        m_eff = m_fix[M_W-1:0];
        bad   = (m_in == '0) || (a_x > m_x);
    end
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
    import psd_pkg::*;
(
    input  logic             clk,
    input  logic             clr,
    input  modsel_e          sel,
    output logic [PRE_W-1:0] cnt,
    output logic             tc,
    output logic             base_win
);
    always_ff @(posedge clk) begin
        if (clr)     cnt <= '0;
        else if (tc) cnt <= '0;
        else         cnt <= cnt + 1'b1;
    end

    always_comb begin
        tc       = !clr && (cnt == pre_last(sel));
        base_win = (cnt < PRE_W'(PRE_BASE));
    end
endmodule

// File: rtl/psd_period_ctl.sv
module psd_period_ctl
    import psd_pkg::*;
#(
    parameter int M_W = 8
) (
    input  logic           clk,
    input  logic           load,
    input  logic           step,
    input  logic [M_W-1:0] a_eff,
    input  logic [M_W-1:0] m_eff,
    input  logic           bad_in,
    output modsel_e        sel,
    output logic           first_cyc,
    output logic           bad_q
);
    logic [M_W-1:0] idx, a_q, m_q;
    logic           last_cyc;

    always_comb begin
        sel       = (idx < a_q) ? MOD_EXT : MOD_BASE;
        last_cyc  = (idx == m_q - 1'b1);
        first_cyc = (idx == '0);
    end

    always_ff @(posedge clk) begin
        if (load || (step && last_cyc)) begin
            idx   <= '0;
            a_q   <= a_eff;
            m_q   <= m_eff;
            bad_q <= bad_in;
        end else if (step) begin
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/psd_top.sv
module psd_top
    import psd_pkg::*;
#(
    parameter int A_W = 6,
    parameter int M_W = 8
) (
    input  logic           clk,
    input  logic           hold,
    input  logic [A_W-1:0] swallow_in,
    input  logic [M_W-1:0] main_in,
    output logic           div_out,
    output logic           cfg_bad
);
    logic [M_W-1:0]   a_eff, m_eff;
    logic             bad_now;
    logic             running;
    logic [PRE_W-1:0] pre_cnt;
    logic             pre_tc, base_win, first_cyc;
    modsel_e          sel;

    psd_cfg_clamp #(.A_W(A_W), .M_W(M_W)) u_clamp (
        .a_in (swallow_in),
        .m_in (main_in),
        .a_eff(a_eff),
        .m_eff(m_eff),
        .bad  (bad_now)
    );

    always_ff @(posedge clk) begin
        if (hold) running <= 1'b0;
        else      running <= 1'b1;
    end

    psd_prescaler u_pre (
        .clk     (clk),
        .clr     (hold || !running),
        .sel     (sel),
        .cnt     (pre_cnt),
        .tc      (pre_tc),
        .base_win(base_win)
    );

    psd_period_ctl #(.M_W(M_W)) u_ctl (
        .clk      (clk),
        .load     (hold),
        .step     (running && pre_tc),
        .a_eff    (a_eff),
        .m_eff    (m_eff),
        .bad_in   (bad_now),
        .sel      (sel),
        .first_cyc(first_cyc),
        .bad_q    (cfg_bad)
    );

    assign div_out = running && first_cyc && base_win;
endmodule

// File: rtl/psd_checks.sv
module psd_checks
    import psd_pkg::*;
(
    input logic             clk,
    input logic             hold,
    input logic             div_out,
    input logic             cfg_bad,
    input logic [PRE_W-1:0] pre_cnt
);
    logic [15:0] hi_run;

    always_ff @(posedge clk) begin
        if (hold || !div_out) hi_run <= '0;
        else if (hi_run != 16'hFFFF) hi_run <= hi_run + 1'b1;
    end

    AST_HOLD_QUIET: assert property (@(posedge clk)
        hold |=> !div_out);  // R4

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (hold)
        ($fell(div_out) && !$past(hold)) |-> (hi_run == 16'd8));  // R2

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (hold)
        pre_cnt <= PRE_W'(PRE_BASE));  // R1

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (hold)
        !$stable(cfg_bad) |-> ($past(hold) || $rose(div_out)));  // R8
endmodule

bind psd_top psd_checks u_chk (
    .clk    (clk),
    .hold   (hold),
    .div_out(div_out),
    .cfg_bad(cfg_bad),
    .pre_cnt(pre_cnt)
);

// File: tb/psd_top_tb.sv
`timescale 1ns/1ps
module psd_top_tb;
    logic       clk = 1'b0;
    logic       hold = 1'b1;
    logic [5:0] swallow_in = '0;
    logic [7:0] main_in = 8'd4;
    logic       div_out, cfg_bad;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    psd_top u_dut (
        .clk       (clk),
        .hold      (hold),
        .swallow_in(swallow_in),
        .main_in   (main_in),
        .div_out   (div_out),
        .cfg_bad   (cfg_bad)
    );

    // swallow, main, expected ratio, expected cfg_bad
    localparam int NV = 7;
    localparam int VEC [NV][4] = '{
        '{3,  10, 83,  0},   // R1
        '{0,  5,  40,  0},   // R3
        '{7,  7,  63,  0},   // R9
        '{12, 4,  36,  1},   // R6
        '{1,  2,  17,  0},   // R1
        '{5,  0,  9,   1},   // R7
        '{20, 40, 340, 0}    // R1
    };

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called with div_out high at a negedge; returns high width and full period
    task automatic measure(output int hi, output int per);
        hi = 0; per = 0;
        while (div_out && hi < 5000) begin hi++; per++; @(negedge clk); end
        while (!div_out && per < 5000) begin per++; @(negedge clk); end
    endtask

    task automatic start_with(input int a, input int m);
        @(negedge clk);
        hold = 1'b1; swallow_in = 6'(a); main_in = 8'(m);
        repeat (2) @(negedge clk);
        hold = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int hi, per;
        // reset state: output low while held (R4)
        repeat (3) @(negedge clk);
        check("R4 reset low", int'(div_out), 0);

        for (int v = 0; v < NV; v++) begin
            start_with(VEC[v][0], VEC[v][1]);
            check("R4 first pulse", int'(div_out), 1);
            check("R8 cfg_bad", int'(cfg_bad), VEC[v][3]);
            for (int k = 0; k < 2; k++) begin
                measure(hi, per);
                check("R2 width", hi, 8);
                check("R1/R3/R6/R7/R9 period", per, VEC[v][2]);
            end
        end

        // R5: new setting lands only at the period boundary
        start_with(2, 6);
        swallow_in = 6'd0; main_in = 8'd3;
        measure(hi, per);
        check("R5 old period", per, 50);
        measure(hi, per);
        check("R5 new period", per, 24);
        check("R5 width", hi, 8);

        // R8: status tracks loaded setting, updates at boundary
        swallow_in = 6'd9; main_in = 8'd3;
        check("R8 cfg_bad before boundary", int'(cfg_bad), 0);
        measure(hi, per);
        check("R8 cfg_bad after boundary", int'(cfg_bad), 1);
        check("R6 clamped period", per, 24);
        measure(hi, per);
        check("R6 clamped new period", per, 27);

        // R4: hold mid-run forces output low
        repeat (3) @(negedge clk);
        hold = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 12; c++) begin
            check("R4 held low", int'(div_out), 0);
            @(negedge clk);
        end
        hold = 1'b0;
        @(negedge clk);
        check("R4 restart", int'(div_out), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule